// File: doc/BRIEF.md
# Memory Burst-Compare Engine

This block walks a range of memory words one at a time and compares each word with a fixed expected value, either all zeros or all ones. It is meant for blank checks and erase checks. Software arms it through a single 32-bit control/status register, together with a start address and a word count presented on dedicated inputs. The engine drives a synchronous read port with one cycle of read latency. Before each read it checks that the address lies inside the region picked by the memory-type field.

Progress is shown as a two-bit state code: idle, pending, running or complete. Two sticky flags report a compare mismatch and an access to a reserved region. Once the run has finished, the complete state and the flags stay put until software clears them. While the engine is not idle, the configuration fields cannot be changed. A start request is dropped while the low-frequency indication input is high.

Top module: `bcmp_engine`

## Requirements
- R1: After a synchronous reset the register reads 32'h0000_0000, the state code (bits 17:16) is idle (00) and no memory read is issued.
- R2: When 1 is written to bit 0 while the state is idle and the low-frequency input is low, the state reads pending (01) for exactly one cycle and then running (10).
- R3: A start write is ignored while the low-frequency input is high: the state stays idle and no read is issued. Bit 0 always reads 0.
- R4: Bit 4 selects the expected word: 0 selects 32'h0000_0000 and 1 selects 32'hFFFF_FFFF. If every word in the range matches, the run reaches complete (11) with both flags at 0 and exactly length reads.
- R5: With bit 3 (stop on mismatch) at 0, every word of the range is read. Any mismatch sets the compare-error flag (bit 18).
- R6: With bit 3 at 1, the run completes at the first mismatching word, so the number of reads is the index of that word plus one. The compare-error flag is set.
- R7: The complete state holds until 1 is written to bit 23. That write returns the state to idle and clears bits 19:18.
- R8: A write of 1 to bit 23 in any state other than complete has no effect, and a write of 0 to bit 23 in the complete state has no effect.
- R9: Bits 4, 3 and 2:1 can be written only while the state is idle. In every other state they keep their values.
- R10: Memory type 00 selects the main region and 01 selects the information region. When the current address lies outside the selected region, or the type is a reserved code (10, 11), the address-error flag (bit 19) is set, the run completes and that address is not read.
- R11: Bits 31:24, 22:20 and 15:5 read as 0. The register read port returns the register contents one cycle after they change.
- R12: A run of length 0 reaches complete with no reads and no flags set.
- R13: A mismatch on the last word of the region and the address error on the word after it land in the same cycle, and both flags end up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered register read data |
| lowfreq | input | 1 | Low-frequency mode indication; blocks start |
| start_addr | input | AW (8) | First word address of the range |
| length | input | LW (9) | Number of words to compare |
| mem_rd_en | output | 1 | Memory read enable |
| mem_addr | output | AW (8) | Memory read address |
| mem_rdata | input | DW (32) | Memory read data, valid one cycle after mem_rd_en |

## Verification
Two events can fall in the same cycle: the compare of a word returned from memory, and the range check of the next address. The bench provokes this by starting a scan two words before the end of the main region with stop-on-mismatch off and a bad value in the final valid word. The read data for that word then comes back in the same cycle that the out-of-region address is detected. The bench passes this case only if both sticky flags are set, the state is complete and exactly two reads were issued.

// File: rtl/bcmp_pkg.sv
package bcmp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_PEND = 2'b01,
    ST_RUN  = 2'b10,
    ST_DONE = 2'b11
  } bst_t;

  localparam int BIT_CLR   = 23;
  localparam int BIT_AERR  = 19;
  localparam int BIT_CERR  = 18;
  localparam int BIT_STLO  = 16;
  localparam int BIT_PAT   = 4;
  localparam int BIT_STOP  = 3;
  localparam int BIT_MTLO  = 1;
  localparam int BIT_GO    = 0;

  localparam logic [1:0] MT_MAIN = 2'b00;
  localparam logic [1:0] MT_INFO = 2'b01;

  typedef struct packed {
    logic       pat;
    logic       stop;
    logic [1:0] mtype;
  } bcfg_t;

endpackage

// File: rtl/bcmp_regs.sv
module bcmp_regs
  import bcmp_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_we,
  input  logic [31:0] reg_wdata,
  input  logic        lowfreq,
  input  bst_t        stat,
  input  logic        addr_err,
  input  logic        cmp_err,
  output bcfg_t       cfg,
  output logic        start_acc,
  output logic        clr_acc,
  output logic [31:0] reg_rdata
);

  logic is_idle;
  assign is_idle   = (stat == ST_IDLE);
  assign start_acc = reg_we && reg_wdata[BIT_GO] && is_idle && !lowfreq;
  assign clr_acc   = reg_we && reg_wdata[BIT_CLR] && (stat == ST_DONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= '0;
    end else if (reg_we && is_idle) begin
      cfg.pat   <= reg_wdata[BIT_PAT];
      cfg.stop  <= reg_wdata[BIT_STOP];
      cfg.mtype <= reg_wdata[BIT_MTLO +: 2];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      reg_rdata                <= '0;
      reg_rdata[BIT_AERR]      <= addr_err;
      reg_rdata[BIT_CERR]      <= cmp_err;
      reg_rdata[BIT_STLO +: 2] <= stat;
      reg_rdata[BIT_PAT]       <= cfg.pat;
      reg_rdata[BIT_STOP]      <= cfg.stop;
      reg_rdata[BIT_MTLO +: 2] <= cfg.mtype;
    end
  end

  // R9
  cfg_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (stat != ST_IDLE) |=> $stable(cfg));

endmodule

// File: rtl/bcmp_seq.sv
module bcmp_seq
  import bcmp_pkg::*;
#(
  parameter int AW         = 8,
  parameter int LW         = 9,
  parameter int DW         = 32,
  parameter int MAIN_BASE  = 0,
  parameter int MAIN_WORDS = 128,
  parameter int INFO_BASE  = 192,
  parameter int INFO_WORDS = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_acc,
  input  logic          clr_acc,
  input  bcfg_t         cfg,
  input  logic [AW-1:0] start_addr,
  input  logic [LW-1:0] length,
  input  logic [DW-1:0] mem_rdata,
  output bst_t          stat,
  output logic          addr_err,
  output logic          cmp_err,
  output logic          mem_rd_en,
  output logic [AW-1:0] mem_addr
);

  localparam int XW = AW + 1;
  localparam logic [XW-1:0] MAIN_LO = XW'(MAIN_BASE);
  localparam logic [XW-1:0] MAIN_SZ = XW'(MAIN_WORDS);
  localparam logic [XW-1:0] INFO_LO = XW'(INFO_BASE);
  localparam logic [XW-1:0] INFO_SZ = XW'(INFO_WORDS);

  logic [XW-1:0] cur;
  logic [LW-1:0] issued, len_q;
  logic          rv;
  logic          addr_good, in_run, remaining, mismatch, stop_now;
  logic          want_issue, bad_addr, finish;
  logic [DW-1:0] expected;

  always_comb begin
    case (cfg.mtype)
      MT_MAIN: addr_good = (XW'(cur - MAIN_LO) < MAIN_SZ);
      MT_INFO: addr_good = (XW'(cur - INFO_LO) < INFO_SZ);
      default: addr_good = 1'b0;
    endcase
  end

  assign expected   = {DW{cfg.pat}};
  assign in_run     = (stat == ST_RUN);
  assign remaining  = (issued != len_q);
  assign mismatch   = in_run && rv && (mem_rdata != expected);
  assign stop_now   = mismatch && cfg.stop;
  assign want_issue = in_run && remaining && !stop_now;
  assign mem_rd_en  = want_issue && addr_good;
  assign bad_addr   = want_issue && !addr_good;
  assign finish     = in_run && (stop_now || bad_addr || (!remaining && !rv));
  assign mem_addr   = cur[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      stat     <= ST_IDLE;
      cur      <= '0;
      issued   <= '0;
      len_q    <= '0;
      rv       <= 1'b0;
      addr_err <= 1'b0;
      cmp_err  <= 1'b0;
    end else begin
      rv <= mem_rd_en;
      case (stat)
        ST_IDLE: if (start_acc) begin
          stat   <= ST_PEND;
          cur    <= {1'b0, start_addr};
          len_q  <= length;
          issued <= '0;
        end
        ST_PEND: stat <= ST_RUN;
        ST_RUN: begin
          if (mem_rd_en) begin
            cur    <= cur + 1'b1;
            issued <= issued + 1'b1;
          end
          if (mismatch) cmp_err  <= 1'b1;
          if (bad_addr) addr_err <= 1'b1;
          if (finish)   stat     <= ST_DONE;
        end
        default: if (clr_acc) begin
          stat     <= ST_IDLE;
          addr_err <= 1'b0;
          cmp_err  <= 1'b0;
        end
      endcase
    end
  end

  // R2
  pend_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    (stat == ST_PEND) |=> (stat == ST_RUN));

  // R7
  done_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (stat == ST_DONE && !clr_acc) |=> (stat == ST_DONE));

  // R10
  aerr_done_chk: assert property (@(posedge clk) disable iff (rst)
    addr_err |-> (stat == ST_DONE));

  // R6
  stop_fail_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg.stop && cmp_err) |-> (stat == ST_DONE));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (stat == ST_IDLE) |-> (!mem_rd_en && !addr_err && !cmp_err));

endmodule

// File: rtl/bcmp_engine.sv
module bcmp_engine
  import bcmp_pkg::*;
#(
  parameter int AW         = 8,
  parameter int LW         = 9,
  parameter int DW         = 32,
  parameter int MAIN_BASE  = 0,
  parameter int MAIN_WORDS = 128,
  parameter int INFO_BASE  = 192,
  parameter int INFO_WORDS = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_we,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          lowfreq,
  input  logic [AW-1:0] start_addr,
  input  logic [LW-1:0] length,
  output logic          mem_rd_en,
  output logic [AW-1:0] mem_addr,
  input  logic [DW-1:0] mem_rdata
);

  bst_t  stat;
  bcfg_t cfg;
  logic  start_acc, clr_acc, addr_err, cmp_err;

  bcmp_regs u_regs (
    .clk       (clk),
    .rst       (rst),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .lowfreq   (lowfreq),
    .stat      (stat),
    .addr_err  (addr_err),
    .cmp_err   (cmp_err),
    .cfg       (cfg),
    .start_acc (start_acc),
    .clr_acc   (clr_acc),
    .reg_rdata (reg_rdata)
  );

  bcmp_seq #(
    .AW(AW), .LW(LW), .DW(DW),
    .MAIN_BASE(MAIN_BASE), .MAIN_WORDS(MAIN_WORDS),
    .INFO_BASE(INFO_BASE), .INFO_WORDS(INFO_WORDS)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .start_acc  (start_acc),
    .clr_acc    (clr_acc),
    .cfg        (cfg),
    .start_addr (start_addr),
    .length     (length),
    .mem_rdata  (mem_rdata),
    .stat       (stat),
    .addr_err   (addr_err),
    .cmp_err    (cmp_err),
    .mem_rd_en  (mem_rd_en),
    .mem_addr   (mem_addr)
  );

endmodule

// File: tb/bcmp_engine_tb.sv
module bcmp_engine_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        lowfreq = 1'b0;
  logic [7:0]  start_addr = '0;
  logic [8:0]  length = '0;
  logic        mem_rd_en;
  logic [7:0]  mem_addr;
  logic [31:0] mem_rdata = '0;

  logic [31:0] mem [256];
  int n_reads = 0;
  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcmp_engine u_dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .lowfreq(lowfreq), .start_addr(start_addr),
    .length(length), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (mem_rd_en) begin
      mem_rdata <= mem[mem_addr];
      n_reads   <= n_reads + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  function automatic logic [31:0] cfgw(input bit pat, input bit stop, input logic [1:0] mt, input bit go);
    return {27'd0, pat, stop, mt, go};
  endfunction

  task automatic fill(input logic [31:0] v);
    for (int i = 0; i < 256; i++) mem[i] = v;
  endtask

  task automatic wait_done();
    bit seen = 0;
    for (int i = 0; i < 3000 && !seen; i++) begin
      @(negedge clk);
      if (reg_rdata[17:16] == 2'b11) seen = 1;
    end
  endtask

  task automatic run(input bit pat, input bit stop, input logic [1:0] mt,
                     input logic [7:0] sa, input logic [8:0] len);
    start_addr = sa; length = len;
    @(negedge clk);
    n_reads = 0;
    wr(cfgw(pat, stop, mt, 1'b1));
    wait_done();
    @(negedge clk);
  endtask

  task automatic clear();
    wr(32'h0080_0000);
    @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reg after reset", reg_rdata, 32'h0);
    chk("R1 no read after reset", {31'd0, mem_rd_en}, 32'h0);
  endtask

  task automatic t_start_timing();
    fill(32'h0);
    start_addr = 8'd0; length = 9'd20;
    wr(cfgw(0, 0, 2'b00, 1));
    @(negedge clk);
    chk("R2 pending state", {30'd0, reg_rdata[17:16]}, 32'd1);
    @(negedge clk);
    chk("R2 running state", {30'd0, reg_rdata[17:16]}, 32'd2);
    chk("R11 start bit reads 0", {31'd0, reg_rdata[0]}, 32'd0);
    wait_done();
    clear();
  endtask

  task automatic t_lowfreq();
    lowfreq = 1'b1;
    n_reads = 0;
    wr(cfgw(0, 0, 2'b00, 1));
    repeat (3) @(negedge clk);
    chk("R3 start ignored in low freq", {30'd0, reg_rdata[17:16]}, 32'd0);
    chk("R3 no reads in low freq", n_reads, 32'd0);
    lowfreq = 1'b0;
  endtask

  task automatic t_pattern();
    fill(32'h0);
    run(0, 0, 2'b00, 8'd0, 9'd128);
    chk("R4 zero blank status", reg_rdata[19:16], 4'b0011);
    chk("R4 zero blank reads", n_reads, 32'd128);
    clear();
    chk("R7 clear returns idle", reg_rdata[19:16], 4'b0000);
    fill(32'hFFFF_FFFF);
    run(1, 0, 2'b01, 8'd192, 9'd32);
    chk("R4 ones blank status", reg_rdata[19:16], 4'b0011);
    chk("R4 ones blank reads", n_reads, 32'd32);
    clear();
  endtask

  task automatic t_scan_all();
    fill(32'h0);
    mem[13] = 32'h0000_0100;
    run(0, 0, 2'b00, 8'd10, 9'd10);
    chk("R5 flags after full scan", reg_rdata[19:16], 4'b0111);
    chk("R5 reads full range", n_reads, 32'd10);
    wr(32'h0);
    @(negedge clk);
    chk("R8 zero to clear bit keeps done", reg_rdata[19:16], 4'b0111);
    clear();
    chk("R7 flags cleared", reg_rdata[19:16], 4'b0000);
  endtask

  task automatic t_stop_first();
    fill(32'hFFFF_FFFF);
    mem[40 + 3] = 32'hFFFF_7FFF;
    mem[40 + 6] = 32'h0;
    run(1, 1, 2'b00, 8'd40, 9'd20);
    chk("R6 flags at stop", reg_rdata[19:16], 4'b0111);
    chk("R6 reads up to mismatch", n_reads, 32'd4);
    clear();
  endtask

  task automatic t_clear_lock();
    fill(32'h0);
    start_addr = 8'd0; length = 9'd100;
    n_reads = 0;
    wr(cfgw(0, 0, 2'b00, 1));
    repeat (4) @(negedge clk);
    wr(32'h0080_001E);
    @(negedge clk);
    chk("R8 clear ignored while running", {30'd0, reg_rdata[17:16]}, 32'd2);
    chk("R9 cfg locked while running", {28'd0, reg_rdata[4:1]}, 32'd0);
    wait_done();
    @(negedge clk);
    chk("R9 locked cfg kept run clean", reg_rdata[19:16], 4'b0011);
    chk("R9 reads with locked cfg", n_reads, 32'd100);
    clear();
  endtask

  task automatic t_addr_err();
    fill(32'h0);
    run(0, 0, 2'b10, 8'd0, 9'd5);
    chk("R10 reserved type flags", reg_rdata[19:16], 4'b1011);
    chk("R10 reserved type no reads", n_reads, 32'd0);
    clear();
    run(0, 0, 2'b00, 8'd150, 9'd5);
    chk("R10 start outside region", reg_rdata[19:16], 4'b1011);
    chk("R10 outside no reads", n_reads, 32'd0);
    clear();
    run(0, 0, 2'b01, 8'd220, 9'd8);
    chk("R10 range crosses info end", reg_rdata[19:16], 4'b1011);
    chk("R10 reads before crossing", n_reads, 32'd4);
    clear();
  endtask

  task automatic t_same_cycle();
    fill(32'h0);
    mem[127] = 32'h5;
    run(0, 0, 2'b00, 8'd126, 9'd4);
    chk("R13 both flags set", reg_rdata[19:16], 4'b1111);
    chk("R13 reads", n_reads, 32'd2);
    clear();
  endtask

  task automatic t_zero_len();
    run(0, 0, 2'b00, 8'd5, 9'd0);
    chk("R12 zero length done", reg_rdata[19:16], 4'b0011);
    chk("R12 zero length reads", n_reads, 32'd0);
    clear();
  endtask

  task automatic t_layout();
    wr(32'hFFFF_FFFE);
    @(negedge clk);
    chk("R11 reserved bits zero", reg_rdata, 32'h0000_001E);
    wr(32'h0);
    @(negedge clk);
    chk("R11 cfg cleared in idle", reg_rdata, 32'h0);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    fill(32'h0);
    t_reset();
    t_start_timing();
    t_lowfreq();
    t_pattern();
    t_scan_all();
    t_stop_first();
    t_clear_lock();
    t_addr_err();
    t_same_cycle();
    t_zero_len();
    t_layout();
    finish_run();
  end

endmodule